// File: doc/BRIEF.md
# Working Register File with Indirect Pointers

This block holds the 32 eight-bit working registers of a small 8-bit processor core. Two combinational read ports feed the execution unit, and the first port also presents the aligned register pair as one 16-bit operand. A single write port stores either one byte or a 16-bit result into an even/odd pair. Together these cover four operand shapes: one byte in and one byte out, two bytes in and one byte out, two bytes in and a 16-bit result out, and a 16-bit operand in with a 16-bit result out.

The same storage also answers the lowest 32 addresses of the data space. A load or store aimed at address n reaches register n, and a hit flag tells the surrounding memory decoder that the block claimed the access. The top six registers pair up into three 16-bit indirect pointers, called X, Y and Z here. Each pointer has its own output. A small update helper performs post-increment or pre-decrement on a selected pointer and presents the effective address in that same cycle.

Top module: `regfile_ptr`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 registers to zero at the rising clock edge.
- R2: `rd_a_data` and `rd_b_data` show the registers selected by `rd_a_idx` and `rd_b_idx` combinationally. In a cycle that writes the register being read, they return the old value, and the new value appears after the edge.
- R3: With `wr_en`=1 and `wr_wide`=0, `wr_data[7:0]` is stored into register `wr_idx` at the rising edge.
- R4: With `wr_en`=1 and `wr_wide`=1, bit 0 of `wr_idx` is ignored. `wr_data[7:0]` goes to the even register {`wr_idx[4:1]`,0} and `wr_data[15:8]` goes to the odd register {`wr_idx[4:1]`,1}, both on the same edge. `rd_pair_data` shows {odd, even} of the pair that contains `rd_a_idx`.
- R5: For `ds_addr` below 0x20, `ds_hit` is 1 and `ds_rdata` shows register `ds_addr[4:0]`. With `ds_we`=1, `ds_wdata` is stored there at the edge.
- R6: For `ds_addr` of 0x20 or above, `ds_hit` is 0 and `ds_rdata` is 0. A write with `ds_we`=1 changes no register, including the register that the low five address bits would alias.
- R7: `ptr_x` is {R27,R26}, `ptr_y` is {R29,R28} and `ptr_z` is {R31,R30}. The lower-numbered register is the low byte.
- R8: `ptr_sel` selects the pointer (0 none, 1 X, 2 Y, 3 Z) and `ptr_op` selects the operation (0 or 3 hold, 1 post-increment, 2 pre-decrement). For hold and post-increment, `ptr_addr` shows the current pointer value. Post-increment stores value+1 modulo 65536 at the edge, and hold leaves the pointer unchanged.
- R9: For pre-decrement, `ptr_addr` shows the value-1 modulo 65536 in that cycle, and that value is stored into the pointer at the edge.
- R10: Only one write source takes effect per edge. The register-port write wins over a data-space write that hits, which wins over a pointer update. The losing sources change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| rd_pair_data | output | 16 | Aligned pair containing rd_a_idx, {odd, even} |
| wr_en | input | 1 | Register-port write enable |
| wr_wide | input | 1 | 1: 16-bit pair write, 0: byte write |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 16 | Write data (low byte only for byte writes) |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data, 0 on miss |
| ds_hit | output | 1 | Address falls inside the register window |
| ptr_sel | input | 2 | Pointer select: 0 none, 1 X, 2 Y, 3 Z |
| ptr_op | input | 2 | 0/3 hold, 1 post-increment, 2 pre-decrement |
| ptr_addr | output | 16 | Effective address for the pointer access |
| ptr_x | output | 16 | X pointer |
| ptr_y | output | 16 | Y pointer |
| ptr_z | output | 16 | Z pointer |

## Verification
The bench aims at pointer wrap in both directions. A design that drops the carry or borrow into the high byte would show 0x00FF or 0xFF00 instead of 0x0000 or 0xFFFF. It writes to data addresses 0x20 and 0x25, which alias registers 0 and 5 in their low bits, so a decoder that looks only at five bits would corrupt those registers. Wide writes with an odd index catch a design that fails to force the even alignment. Stacked simultaneous writes expose a wrong priority, because a pointer update or data-space store would overwrite the port result.

// File: rtl/regfile_ptr.sv
module regfile_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    rd_a_idx,
  output logic [7:0]    rd_a_data,
  input  logic [4:0]    rd_b_idx,
  output logic [7:0]    rd_b_data,
  output logic [15:0]   rd_pair_data,
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic [4:0]    wr_idx,
  input  logic [15:0]   wr_data,
  input  logic [AW-1:0] ds_addr,
  input  logic          ds_we,
  input  logic [7:0]    ds_wdata,
  output logic [7:0]    ds_rdata,
  output logic          ds_hit,
  input  logic [1:0]    ptr_sel,
  input  logic [1:0]    ptr_op,
  output logic [15:0]   ptr_addr,
  output logic [15:0]   ptr_x,
  output logic [15:0]   ptr_y,
  output logic [15:0]   ptr_z
);
  localparam int NREG = 32;
  localparam logic [4:0] PBASE = 5'd24;

  logic [7:0]  rf [NREG];
  logic [4:0]  plo;
  logic [15:0] pcur, pnext;
  logic        pupd;

  assign rd_a_data    = rf[rd_a_idx];
  assign rd_b_data    = rf[rd_b_idx];
  assign rd_pair_data = {rf[{rd_a_idx[4:1], 1'b1}], rf[{rd_a_idx[4:1], 1'b0}]};

  assign ds_hit   = (ds_addr[AW-1:5] == '0);
  assign ds_rdata = ds_hit ? rf[ds_addr[4:0]] : 8'h00;

  assign ptr_x = {rf[27], rf[26]};
  assign ptr_y = {rf[29], rf[28]};
  assign ptr_z = {rf[31], rf[30]};

  assign plo  = PBASE + {2'b00, ptr_sel, 1'b0};
  assign pcur = {rf[{plo[4:1], 1'b1}], rf[{plo[4:1], 1'b0}]};
  assign pupd = (ptr_sel != 2'd0) && (ptr_op == 2'd1 || ptr_op == 2'd2);

  always_comb begin
    pnext    = pcur;
    ptr_addr = pcur;
    if (ptr_op == 2'd1) pnext = pcur + 16'd1;
    if (ptr_op == 2'd2) begin
      pnext    = pcur - 16'd1;
      ptr_addr = pnext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
    end else if (wr_en) begin
      if (wr_wide) begin
        rf[{wr_idx[4:1], 1'b0}] <= wr_data[7:0];
        rf[{wr_idx[4:1], 1'b1}] <= wr_data[15:8];
      end else begin
        rf[wr_idx] <= wr_data[7:0];
      end
    end else if (ds_we && ds_hit) begin
      rf[ds_addr[4:0]] <= ds_wdata;
    end else if (pupd) begin
      rf[{plo[4:1], 1'b0}] <= pnext[7:0];
      rf[{plo[4:1], 1'b1}] <= pnext[15:8];
    end
  end
endmodule

module regfile_ptr_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        wr_wide,
  input logic [4:0]  wr_idx,
  input logic [15:0] wr_data,
  input logic        ds_we,
  input logic        ds_hit,
  input logic [1:0]  ptr_sel,
  input logic [1:0]  ptr_op,
  input logic [15:0] ptr_addr,
  input logic [15:0] ptr_x,
  input logic [15:0] ptr_z
);
  AST_WIDE_X: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_wide && wr_idx[4:1] == 4'd13 |=> ptr_x == $past(wr_data)); // R4

  AST_POST_INC: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !(ds_we && ds_hit) && ptr_sel == 2'd1 && ptr_op == 2'd1
    |=> ptr_x == $past(ptr_x) + 16'd1); // R8

  AST_PRE_DEC: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !(ds_we && ds_hit) && ptr_sel == 2'd3 && ptr_op == 2'd2
    |=> ptr_z == $past(ptr_addr)); // R9

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ds_we && !ds_hit && !wr_en && ptr_sel == 2'd0
    |=> $stable(ptr_x) && $stable(ptr_z)); // R6

  AST_PORT_FIRST: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_wide && wr_idx == 5'd26 && ptr_sel == 2'd1
    |=> ptr_x == {$past(ptr_x[15:8]), $past(wr_data[7:0])}); // R10
endmodule

bind regfile_ptr regfile_ptr_chk u_chk (.*);

// File: tb/regfile_ptr_bench.sv
`timescale 1ns/1ps
module regfile_ptr_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [7:0] rd_a_data, rd_b_data, ds_rdata, ds_wdata = '0;
  logic [15:0] rd_pair_data, wr_data = '0, ds_addr = '0;
  logic [15:0] ptr_addr, ptr_x, ptr_y, ptr_z;
  logic wr_en = 1'b0, wr_wide = 1'b0, ds_we = 1'b0, ds_hit;
  logic [1:0] ptr_sel = '0, ptr_op = '0;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regfile_ptr u_regfile_ptr (.*);

  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {5'd0, 8'hA5}, {5'd1, 8'h3C}, {5'd15, 8'hFF}, {5'd16, 8'h01},
    {5'd26, 8'h34}, {5'd27, 8'h12}, {5'd31, 8'h80}, {5'd13, 8'h7E}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_wide = 0; ds_we = 0; ptr_sel = 0; ptr_op = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 0;
    chk("R1 reset ptr_x", ptr_x, 16'h0);
    chk("R1 reset ptr_z", ptr_z, 16'h0);

    for (int i = 0; i < NV; i++) begin
      wr_en = 1; wr_idx = VEC[i][12:8]; wr_data = {8'h00, VEC[i][7:0]};
      rd_a_idx = VEC[i][12:8];
      #1 chk("R2 old value before edge", {8'h0, rd_a_data}, 16'h0);
      step();
      idle(); ds_addr = {11'h0, VEC[i][12:8]};
      #1;
      chk("R3 port read after write", {8'h0, rd_a_data}, {8'h0, VEC[i][7:0]});
      chk("R5 data-space read", {7'h0, ds_hit, ds_rdata}, {7'h0, 1'b1, VEC[i][7:0]});
    end
    chk("R7 X from R27:R26", ptr_x, 16'h1234);

    wr_en = 1; wr_wide = 1; wr_idx = 5'd29; wr_data = 16'hBEEF;
    step(); idle();
    rd_a_idx = 5'd29; rd_b_idx = 5'd28; #1;
    chk("R4 wide odd idx -> Y", ptr_y, 16'hBEEF);
    chk("R4 low byte in even reg", {8'h0, rd_b_data}, 16'h00EF);
    chk("R4 pair read", rd_pair_data, 16'hBEEF);

    ds_we = 1; ds_addr = 16'h0005; ds_wdata = 8'h99;
    step(); idle(); rd_b_idx = 5'd5; #1;
    chk("R5 data-space write", {8'h0, rd_b_data}, 16'h0099);

    ds_we = 1; ds_addr = 16'h0025; ds_wdata = 8'h44; #1;
    chk("R6 miss hit/rdata", {7'h0, ds_hit, ds_rdata}, 16'h0);
    step();
    ds_addr = 16'h0020; ds_wdata = 8'h11;
    step(); idle(); rd_a_idx = 5'd0; #1;
    chk("R6 alias R5 untouched", {8'h0, rd_b_data}, 16'h0099);
    chk("R6 alias R0 untouched", {8'h0, rd_a_data}, 16'h00A5);

    wr_en = 1; wr_wide = 1; wr_idx = 5'd30; wr_data = 16'hFFFF;
    step(); idle();
    ptr_sel = 2'd3; ptr_op = 2'd1; #1;
    chk("R8 post-inc addr", ptr_addr, 16'hFFFF);
    step();
    chk("R8 post-inc wrap", ptr_z, 16'h0000);
    step(); idle(); #1;
    chk("R8 post-inc again", ptr_z, 16'h0001);

    ptr_sel = 2'd1; ptr_op = 2'd0; step();
    chk("R8 hold", ptr_x, 16'h1234);
    ptr_op = 2'd3; step();
    chk("R8 op3 hold", ptr_x, 16'h1234);

    ptr_op = 2'd2; #1;
    chk("R9 pre-dec addr", ptr_addr, 16'h1233);
    step(); idle(); #1;
    chk("R9 pre-dec stored", ptr_x, 16'h1233);
    wr_en = 1; wr_wide = 1; wr_idx = 5'd28; wr_data = 16'h0000;
    step(); idle();
    ptr_sel = 2'd2; ptr_op = 2'd2; #1;
    chk("R9 pre-dec wrap addr", ptr_addr, 16'hFFFF);
    step(); idle(); #1;
    chk("R9 pre-dec wrap", ptr_y, 16'hFFFF);

    wr_en = 1; wr_idx = 5'd26; wr_data = 16'h0055;
    ds_we = 1; ds_addr = 16'h001A; ds_wdata = 8'h66;
    ptr_sel = 2'd1; ptr_op = 2'd1;
    step();
    chk("R10 port beats others", ptr_x, 16'h1255);
    wr_en = 0; ds_addr = 16'h001B; ds_wdata = 8'h77;
    step(); idle(); #1;
    chk("R10 data-space beats ptr", ptr_x, 16'h7755);

    rst = 1; step(); rst = 0;
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = i[4:0]; #1;
      chk("R1 reset clears reg", {8'h0, rd_a_data}, 16'h0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule